// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers a parameterized number of interrupt request lines (up to 32) and drives one active-low interrupt line towards a processor core. Every line has its own mask bit, trigger style (level or edge), polarity, 3-bit priority and handler address, all set through a single-cycle synchronous register port addressed by 32-bit word. Raw request lines pass through a two-flop synchronizer before any conditioning.

Software services an interrupt by reading the vector register. The read returns the handler address of the best eligible source. It also pushes that source's level onto an internal stack of priority levels. A write to the end-of-interrupt register pops the stack. While a level sits on the stack, only a strictly higher level can pull the interrupt line low again. When the source has vanished by the time of the read, a programmable fallback vector is returned instead, and the stack is still pushed.

A protect mode lets a debugger read the vector without side effects. Set and clear command registers force pending state for test. A separate fast-interrupt request is only synchronized and mirrored to an active-low output.

Top module: `vpic_top`

## Requirements
- R1: A write to the enable command word (0x82) sets every mask bit whose data bit is 1, and a write to the disable command word (0x83) clears every such bit. Other mask bits keep their value. The mask reads back at word 0x84, bit n for source n, and a masked source never causes the interrupt line to go low.
- R2: Each source has a configuration word at address n (0x00..0x1F) with these fields: priority in bits [2:0], edge mode in bit 4 (1 = edge), inversion in bit 5 (1 = active low or falling edge). In level mode, pending bit n (word 0x85) equals the synchronized input XOR the inversion bit.
- R3: In edge mode, an active-going transition of the synchronized input sets a pending latch that holds after the input returns. A vector read that returns that source clears the latch.
- R4: The interrupt output irq_n is low, one cycle after the condition arises, exactly when some enabled pending source has a priority (plus one) above the level on top of the stack. The empty stack counts as level 0, so it sits below priority 0.
- R5: A vector read (word 0x80) returns the handler word of the eligible source with the highest priority. When priorities are equal, the lower index wins. Source n's handler word is at address 0x40+n.
- R6: A vector read pushes the returned level onto an 8-deep stack, and an end-of-interrupt write (word 0x81) pops it. A pending source of equal priority does not preempt, a strictly higher one does, and a pop lets the lower waiting sources through again.
- R7: If no source is eligible at a vector read, the spurious vector (word 0x88) is returned. The current top level is pushed again, so an end-of-interrupt write is still needed.
- R8: When protect bit 0 of word 0x8A is 1, a vector read returns the vector but neither pushes nor clears a latch. A later write to word 0x80 then performs the acknowledge.
- R9: Writing 1s to word 0x86 forces the matching pending bits. Writing 1s to word 0x87 clears both forced and edge-latched state.
- R10: Status word 0x89 holds the index of the last acknowledged source in its low bits, irq_n in bit 8 and fiq_n in bit 9.
- R11: fiq_n is the inverted fast request after a two-flop synchronizer.
- R12: After reset, irq_n and fiq_n are 1, and the mask, pending and configuration words read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NSRC | Raw interrupt request lines |
| fiq_i | input | 1 | Raw fast interrupt request, active high |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects on vector read) |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of bus_rd |
| irq_n | output | 1 | Active-low interrupt request to the core |
| fiq_n | output | 1 | Active-low mirrored fast request |

## Verification
Arbitration is tried on every ordered pair of asserted lines under two priority tables. One table has distinct priorities, which isolates the priority compare. The other has equal pairs, which isolates the index tie-break. Conditioning is swept over each line, each polarity and each input level, which separates the inversion from the synchronizer path. Edge lines are pulsed in both polarities, which shows the latch holding after the input drops and clearing on acknowledge. Nesting scenarios raise equal and higher levels under a pushed level, which separates strict preemption from equal-level blocking. Vanished, masked, protected and forced sources show the fallback vector, the side-effect-free read and the test path.

// File: rtl/vpic_pkg.sv
package vpic_pkg;
  localparam int DW = 32;
  localparam int AW = 8;
  localparam logic [AW-1:0] A_IVR  = 8'h80;
  localparam logic [AW-1:0] A_EOI  = 8'h81;
  localparam logic [AW-1:0] A_EN   = 8'h82;
  localparam logic [AW-1:0] A_DIS  = 8'h83;
  localparam logic [AW-1:0] A_MASK = 8'h84;
  localparam logic [AW-1:0] A_PEND = 8'h85;
  localparam logic [AW-1:0] A_FSET = 8'h86;
  localparam logic [AW-1:0] A_FCLR = 8'h87;
  localparam logic [AW-1:0] A_SPUR = 8'h88;
  localparam logic [AW-1:0] A_STAT = 8'h89;
  localparam logic [AW-1:0] A_PROT = 8'h8A;
  localparam logic [1:0]    PG_CFG = 2'b00;
  localparam logic [1:0]    PG_VEC = 2'b01;
  localparam int CFG_EDGE = 4;
  localparam int CFG_INV  = 5;
  localparam int ST_IRQ   = 8;
  localparam int ST_FIQ   = 9;
endpackage

// File: rtl/vpic_cond.sv
module vpic_cond #(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic [NSRC-1:0] edge_mode,
  input  logic [NSRC-1:0] invert,
  input  logic [NSRC-1:0] ack,
  input  logic [NSRC-1:0] fset,
  input  logic [NSRC-1:0] fclr,
  output logic [NSRC-1:0] pend_o
);
  logic [NSRC-1:0] s1_q, s2_q, s2d_q, elat_q, frc_q;
  logic [NSRC-1:0] active, hit, elat_n, frc_n;

  always_comb begin
    active = s2_q ^ invert;
    hit    = edge_mode & (s2_q ^ s2d_q) & active;
    elat_n = (elat_q & ~ack & ~fclr) | hit;
    frc_n  = (frc_q & ~fclr & ~(ack & edge_mode)) | fset;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= '0;
      s2_q   <= '0;
      s2d_q  <= '0;
      elat_q <= '0;
      frc_q  <= '0;
    end else begin
      s1_q   <= src_i;
      s2_q   <= s1_q;
      s2d_q  <= s2_q;
      elat_q <= elat_n;
      frc_q  <= frc_n;
    end
  end

  assign pend_o = (edge_mode & elat_q) | (~edge_mode & active) | frc_q;
endmodule

// File: rtl/vpic_arb.sv
module vpic_arb #(
  parameter int NSRC = 32,
  parameter int PW   = 3,
  parameter int SW   = 5
) (
  input  logic [NSRC-1:0]    req,
  input  logic [NSRC*PW-1:0] prio_flat,
  output logic               vld,
  output logic [SW-1:0]      idx,
  output logic [PW-1:0]      lvl
);
  always_comb begin
    vld = 1'b0;
    idx = '0;
    lvl = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (req[i] && (!vld || prio_flat[i*PW +: PW] > lvl)) begin
        vld = 1'b1;
        idx = SW'(i);
        lvl = prio_flat[i*PW +: PW];
      end
    end
  end
endmodule

// File: rtl/vpic_stack.sv
module vpic_stack #(
  parameter int DEPTH = 8,
  parameter int LW    = 4,
  parameter int SPW   = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           push,
  input  logic           pop,
  input  logic [LW-1:0]  push_lvl,
  output logic [LW-1:0]  top_lvl,
  output logic [SPW-1:0] sp_o
);
  logic [LW-1:0]  mem_q [DEPTH];
  logic [SPW-1:0] sp_q, sp_n;
  logic           do_push, do_pop;

  always_comb begin
    do_push = push && (sp_q < SPW'(DEPTH));
    do_pop  = !push && pop && (sp_q != '0);
    sp_n    = sp_q;
    if (do_push)     sp_n = sp_q + SPW'(1);
    else if (do_pop) sp_n = sp_q - SPW'(1);
    top_lvl = '0;
    for (int k = 0; k < DEPTH; k++)
      if (sp_q == SPW'(k + 1)) top_lvl = mem_q[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sp_q <= '0;
    else        sp_q <= sp_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) mem_q[k] <= '0;
    end else begin
      for (int k = 0; k < DEPTH; k++)
        if (do_push && sp_q == SPW'(k)) mem_q[k] <= push_lvl;
    end
  end

  assign sp_o = sp_q;
endmodule

// File: rtl/vpic_top.sv
module vpic_top
  import vpic_pkg::*;
#(
  parameter int NSRC  = 32,
  parameter int PW    = 3,
  parameter int DEPTH = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic            fiq_i,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [7:0]      bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  output logic            irq_n,
  output logic            fiq_n
);
  localparam int SW  = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam int LW  = PW + 1;
  localparam int SPW = $clog2(DEPTH + 1);

  logic [PW-1:0]      prio_q [NSRC];
  logic [DW-1:0]      vec_q  [NSRC];
  logic [NSRC-1:0]    mask_q, edge_q, inv_q, mask_n;
  logic [DW-1:0]      spur_q;
  logic               prot_q, irq_n_q, fq1_q, fq2_q;
  logic [SW-1:0]      cur_q, cur_n;
  logic [NSRC*PW-1:0] prio_flat;
  logic [NSRC-1:0]    pend, ack, wd, fset, fclr;
  logic               win_vld, eligible, ivr_rd, ivr_take, pop;
  logic [SW-1:0]      win_idx;
  logic [PW-1:0]      win_prio;
  logic [LW-1:0]      top_lvl, win_lvl, push_lvl;
  logic [SPW-1:0]     sp;
  logic               cfg_we, vec_we;
  logic [5:0]         sel;

  assign wd   = bus_wdata[NSRC-1:0];
  assign sel  = bus_addr[5:0];
  assign fset = (bus_wr && bus_addr == A_FSET) ? wd : '0;
  assign fclr = (bus_wr && bus_addr == A_FCLR) ? wd : '0;

  vpic_cond #(.NSRC(NSRC)) u_cond (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .edge_mode(edge_q), .invert(inv_q),
    .ack(ack), .fset(fset), .fclr(fclr), .pend_o(pend));

  vpic_arb #(.NSRC(NSRC), .PW(PW), .SW(SW)) u_arb (
    .req(pend & mask_q), .prio_flat(prio_flat), .vld(win_vld), .idx(win_idx), .lvl(win_prio));

  vpic_stack #(.DEPTH(DEPTH), .LW(LW), .SPW(SPW)) u_stack (
    .clk(clk), .rst_n(rst_n), .push(ivr_take), .pop(pop), .push_lvl(push_lvl),
    .top_lvl(top_lvl), .sp_o(sp));

  always_comb begin
    for (int s = 0; s < NSRC; s++) prio_flat[s*PW +: PW] = prio_q[s];
    cfg_we   = bus_wr && bus_addr[7:6] == PG_CFG;
    vec_we   = bus_wr && bus_addr[7:6] == PG_VEC;
    ivr_rd   = bus_rd && bus_addr == A_IVR;
    ivr_take = (ivr_rd && !prot_q) || (bus_wr && bus_addr == A_IVR && prot_q);
    pop      = bus_wr && bus_addr == A_EOI;
    win_lvl  = {1'b0, win_prio} + LW'(1);
    eligible = win_vld && (win_lvl > top_lvl);
    push_lvl = eligible ? win_lvl : top_lvl;
    ack      = '0;
    if (ivr_take && eligible) ack[win_idx] = 1'b1;
    cur_n    = (ivr_take && eligible) ? win_idx : cur_q;
    mask_n   = mask_q;
    if (bus_wr && bus_addr == A_EN)  mask_n = mask_q | wd;
    if (bus_wr && bus_addr == A_DIS) mask_n = mask_q & ~wd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      spur_q  <= '0;
      prot_q  <= 1'b0;
      cur_q   <= '0;
      irq_n_q <= 1'b1;
      fq1_q   <= 1'b0;
      fq2_q   <= 1'b0;
    end else begin
      mask_q  <= mask_n;
      cur_q   <= cur_n;
      irq_n_q <= ~eligible;
      fq1_q   <= fiq_i;
      fq2_q   <= fq1_q;
      if (bus_wr && bus_addr == A_SPUR) spur_q <= bus_wdata;
      if (bus_wr && bus_addr == A_PROT) prot_q <= bus_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NSRC; s++) begin
        prio_q[s] <= '0;
        vec_q[s]  <= '0;
      end
      edge_q <= '0;
      inv_q  <= '0;
    end else begin
      for (int s = 0; s < NSRC; s++) begin
        if (cfg_we && int'(sel) == s) begin
          prio_q[s] <= bus_wdata[PW-1:0];
          edge_q[s] <= bus_wdata[CFG_EDGE];
          inv_q[s]  <= bus_wdata[CFG_INV];
        end
        if (vec_we && int'(sel) == s) vec_q[s] <= bus_wdata;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr[7:6] == PG_CFG) begin
      for (int s = 0; s < NSRC; s++)
        if (int'(sel) == s) begin
          bus_rdata[PW-1:0]     = prio_q[s];
          bus_rdata[CFG_EDGE]   = edge_q[s];
          bus_rdata[CFG_INV]    = inv_q[s];
        end
    end else if (bus_addr[7:6] == PG_VEC) begin
      for (int s = 0; s < NSRC; s++)
        if (int'(sel) == s) bus_rdata = vec_q[s];
    end else begin
      case (bus_addr)
        A_IVR:  bus_rdata = eligible ? vec_q[win_idx] : spur_q;
        A_MASK: bus_rdata[NSRC-1:0] = mask_q;
        A_PEND: bus_rdata[NSRC-1:0] = pend;
        A_SPUR: bus_rdata = spur_q;
        A_PROT: bus_rdata[0] = prot_q;
        A_STAT: begin
          bus_rdata[SW-1:0]   = cur_q;
          bus_rdata[ST_IRQ]   = irq_n_q;
          bus_rdata[ST_FIQ]   = ~fq2_q;
        end
        default: bus_rdata = '0;
      endcase
    end
  end

  assign irq_n = irq_n_q;
  assign fiq_n = ~fq2_q;
endmodule

// File: rtl/vpic_chk.sv
module vpic_chk
  import vpic_pkg::*;
#(
  parameter int NSRC  = 32,
  parameter int DEPTH = 8,
  parameter int SPW   = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_wr,
  input logic            bus_rd,
  input logic [7:0]      bus_addr,
  input logic [31:0]     bus_wdata,
  input logic            irq_n,
  input logic [NSRC-1:0] mask,
  input logic [NSRC-1:0] pend,
  input logic [SPW-1:0]  sp,
  input logic            prot
);
  logic ivr_r, eoi_w;
  assign ivr_r = bus_rd && bus_addr == A_IVR;
  assign eoi_w = bus_wr && bus_addr == A_EOI;

  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_EN) |=> ((mask & $past(bus_wdata[NSRC-1:0])) == $past(bus_wdata[NSRC-1:0]))); // R1
  AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_DIS) |=> ((mask & $past(bus_wdata[NSRC-1:0])) == '0)); // R1
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> $past(|(pend & mask))); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    sp <= SPW'(DEPTH)); // R6
  AST_PUSH_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (ivr_r && !prot && sp < SPW'(DEPTH)) |=> sp == $past(sp) + SPW'(1)); // R6
  AST_POP_ON_EOI: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_w && !ivr_r && sp != '0) |=> sp == $past(sp) - SPW'(1)); // R6
  AST_PROT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ivr_r && prot && !bus_wr) |=> $stable(sp)); // R8
endmodule

bind vpic_top vpic_chk #(.NSRC(NSRC), .DEPTH(DEPTH), .SPW(SPW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .irq_n(irq_n), .mask(mask_q), .pend(pend), .sp(sp), .prot(prot_q));

// File: tb/vpic_top_tb.sv
module vpic_top_tb;
  localparam int N = 8;
  logic clk, rst_n, fiq_i, bus_wr, bus_rd, irq_n, fiq_n;
  logic [N-1:0] src_i;
  logic [7:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata, d;
  int nchk, nerr;
  bit done;
  int pt [N];

  vpic_top #(.NSRC(N), .PW(3), .DEPTH(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .fiq_i(fiq_i), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_n(irq_n), .fiq_n(fiq_n));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [31:0] vec(int s);
    return 32'h1000 + 32'(s) * 16;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] v);
    @(negedge clk); bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] v);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    #2 v = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_prio();
    for (int s = 0; s < N; s++) wr(8'(s), 32'(pt[s]));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    nchk = 0; nerr = 0; done = 0;
    rst_n = 0; src_i = '0; fiq_i = 0; bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0;
    idle(3); rst_n = 1; idle(2);

    // R12 reset state
    chk("R12 irq_n", 32'(irq_n), 1);
    chk("R12 fiq_n", 32'(fiq_n), 1);
    rd(8'h84, d); chk("R12 mask", d, 0);
    rd(8'h85, d); chk("R12 pend", d, 0);
    rd(8'h03, d); chk("R12 cfg", d, 0);

    // R1 set/clear commands
    wr(8'h82, 32'h05); rd(8'h84, d); chk("R1 en", d, 32'h05);
    wr(8'h82, 32'h02); rd(8'h84, d); chk("R1 en2", d, 32'h07);
    wr(8'h83, 32'h01); rd(8'h84, d); chk("R1 dis", d, 32'h06);
    wr(8'h83, 32'hFF); rd(8'h84, d); chk("R1 disall", d, 32'h00);
    for (int s = 0; s < N; s++) begin
      wr(8'h82, 32'(1 << s)); rd(8'h84, d); chk("R1 sweep", d, 32'((2 << s) - 1));
    end
    wr(8'h83, 32'hFF);

    // R2 level sweep: every line, polarity, input value
    for (int s = 0; s < N; s++)
      for (int inv = 0; inv < 2; inv++)
        for (int v = 0; v < 2; v++) begin
          wr(8'(s), 32'(inv << 5));
          src_i[s] = v[0]; idle(4);
          rd(8'h85, d); chk("R2 level", 32'(d[s]), 32'(v ^ inv));
          wr(8'(s), 0); src_i = '0; idle(3);
        end

    // vectors, spurious word, enable all
    for (int s = 0; s < N; s++) wr(8'h40 + 8'(s), vec(s));
    wr(8'h88, 32'hBAD0);
    wr(8'h82, 32'hFF);

    // R5 pair sweep: distinct priorities, then equal pairs
    for (int t = 0; t < 2; t++) begin
      for (int s = 0; s < N; s++) pt[s] = (t == 0) ? (s * 5) % 8 : s / 2;
      load_prio();
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++) begin
          int w;
          if (pt[i] > pt[j]) w = i;
          else if (pt[j] > pt[i]) w = j;
          else w = (i < j) ? i : j;
          src_i = N'(1 << i) | N'(1 << j); idle(5);
          chk("R4 irq low", 32'(irq_n), 0);
          rd(8'h80, d); chk("R5 winner", d, vec(w));
          src_i = '0; wr(8'h81, 0); idle(4);
        end
    end

    // R6 nesting: src1,src2 at 3; src4 at 5
    for (int s = 0; s < N; s++) pt[s] = 0;
    pt[1] = 3; pt[2] = 3; pt[4] = 5; load_prio();
    src_i = 8'b0000_0010; idle(5);
    chk("R4 single", 32'(irq_n), 0);
    rd(8'h80, d); chk("R5 first", d, vec(1));
    src_i = 8'b0000_0110; idle(5);
    chk("R6 equal blocked", 32'(irq_n), 1);
    src_i = 8'b0001_0110; idle(5);
    chk("R6 higher preempts", 32'(irq_n), 0);
    rd(8'h80, d); chk("R6 nested vec", d, vec(4));
    rd(8'h89, d); chk("R10 cur src", 32'(d[7:0]), 4);
    src_i = 8'b0000_0110; idle(5);
    chk("R6 top 5 blocks", 32'(irq_n), 1);
    wr(8'h81, 0); idle(3);
    chk("R6 after pop equal", 32'(irq_n), 1);
    wr(8'h81, 0); idle(3);
    chk("R6 empty stack", 32'(irq_n), 0);
    rd(8'h80, d); chk("R5 tie low index", d, vec(1));
    src_i = '0; wr(8'h81, 0); idle(4);

    // R3 rising edge on src5
    wr(8'h05, 32'h11);
    src_i[5] = 1; idle(2); src_i[5] = 0; idle(5);
    rd(8'h85, d); chk("R3 latch holds", 32'(d[5]), 1);
    chk("R3 irq", 32'(irq_n), 0);
    rd(8'h80, d); chk("R3 vec", d, vec(5));
    rd(8'h85, d); chk("R3 cleared", 32'(d[5]), 0);
    idle(2); chk("R3 irq released", 32'(irq_n), 1);
    wr(8'h81, 0);

    // R3 falling edge on src6
    wr(8'h06, 32'h31);
    src_i[6] = 1; idle(5);
    rd(8'h85, d); chk("R3 rise ignored", 32'(d[6]), 0);
    src_i[6] = 0; idle(5);
    rd(8'h85, d); chk("R3 fall latched", 32'(d[6]), 1);
    rd(8'h80, d); chk("R3 fall vec", d, vec(6));
    wr(8'h81, 0); wr(8'h06, 0);

    // R8 protect mode
    src_i[5] = 1; idle(2); src_i[5] = 0; idle(5);
    wr(8'h8A, 1);
    rd(8'h80, d); chk("R8 vec", d, vec(5));
    rd(8'h85, d); chk("R8 no ack", 32'(d[5]), 1);
    chk("R8 irq kept", 32'(irq_n), 0);
    wr(8'h80, 0); idle(2);
    rd(8'h85, d); chk("R8 write acks", 32'(d[5]), 0);
    chk("R8 irq off", 32'(irq_n), 1);
    wr(8'h81, 0); wr(8'h8A, 0); wr(8'h05, 0);

    // R9 forcing
    wr(8'h02, 1);
    wr(8'h86, 32'h04); idle(1);
    rd(8'h85, d); chk("R9 forced", 32'(d[2]), 1);
    chk("R9 irq", 32'(irq_n), 0);
    wr(8'h87, 32'h04);
    rd(8'h85, d); chk("R9 cleared", 32'(d[2]), 0);
    idle(2); chk("R9 irq off", 32'(irq_n), 1);

    // R7 vanished source
    wr(8'h03, 2);
    src_i[3] = 1; idle(5); chk("R7 irq", 32'(irq_n), 0);
    src_i[3] = 0; idle(4);
    rd(8'h80, d); chk("R7 spurious", d, 32'hBAD0);
    wr(8'h81, 0);
    // R1 masked source ignored
    wr(8'h83, 32'h08);
    src_i[3] = 1; idle(5);
    chk("R1 masked irq", 32'(irq_n), 1);
    rd(8'h80, d); chk("R7 masked spurious", d, 32'hBAD0);
    wr(8'h81, 0); src_i = '0; idle(3);

    // R11 fast mirror
    fiq_i = 1; idle(3);
    chk("R11 fiq low", 32'(fiq_n), 0);
    rd(8'h89, d); chk("R10 fiq bit", 32'(d[9]), 0);
    fiq_i = 0; idle(3);
    chk("R11 fiq high", 32'(fiq_n), 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule